// File: doc/BRIEF.md
# SPI Peripheral with Slave-Select Management

This block moves 8-bit frames over a four-wire serial link, most significant bit first, and can take either end of the link. As the clock owner it produces SCK from the system clock through an even divider, sends its shift register on MOSI and fills the same register from MISO. As the follower it samples SCK, MOSI and the select pin through synchronisers, sends its shift register on MISO and fills it from MOSI. Clock polarity and clock phase can be set for both roles.

Whether the block counts as selected is decided by a single internal select level. That level comes either from the select pin or, when software management is on, from a configuration bit, in which case the pin has no effect. The clock owner starts a frame only while this level is high. The follower works only while it is low, and it has rules for when software may reload its shift register. With phase 0 the select must go high between bytes, and reloading is legal only then. With phase 1 the select may stay low across many bytes, and reloading is legal in any gap between frames. A reload at an illegal time is dropped and raises a sticky collision flag. A completion flag marks each finished frame. Both flags are cleared by a status read followed by a data access.

Top module: `spi_ss_core`

## Requirements
- R1: When `cfg_sw_ss_en` is 1, the internal select level equals `cfg_sw_ss_lvl` and `sel_n_i` has no effect on the transfer, start or output-enable behaviour.
- R2: When `cfg_sw_ss_en` is 0, the internal select level follows `sel_n_i` (high = not selected), after the input synchroniser.
- R3: With `cfg_master`=1, a write to the data register while the internal select is low is dropped: no frame starts, `busy` stays 0 and `flag_wcol` stays 0.
- R4: A frame started with `cfg_master`=1 gives 8 SCK cycles, each half period lasting `cfg_div`+1 system clocks. `sck_o` rests at `cfg_cpol` when idle. The written byte leaves on `mosi_o` MSB first. The byte collected from `miso_i` appears on `rd_data`, and `flag_done` is set.
- R5: With `cfg_cpha`=0, data is captured on the leading (first) SCK edge of each bit and changed on the trailing edge. With `cfg_cpha`=1, data is changed on the leading edge and captured on the trailing edge. This holds for both roles.
- R6: With `cfg_master`=0 and `cfg_cpha`=1, several bytes are exchanged while the select stays low throughout, and each byte lands in `rd_data`.
- R7: With `cfg_master`=0 and `cfg_cpha`=0, a data write while the select is low sets `flag_wcol`, and the written byte is discarded: the next frame sends the shift register's previous content.
- R8: A follower write is accepted while the select is high. With `cfg_cpha`=1 a follower write is also accepted while the select is low between frames, and in that case `flag_wcol` stays 0.
- R9: `flag_done` and `flag_wcol` stay set until a `stat_rd` pulse is followed by a data access (`dat_rd` or `wr_en`). A data access with no status read before it leaves them set.
- R10: In follower mode, a rise of the select in the middle of a frame drops the frame: `flag_done` is not set and the next full frame is received correctly.
- R11: While the follower is not selected (or the block is clock owner), `miso_oe` is 0 and `miso_o` rests at 1.
- R12: A clock-owner data write while a frame is in progress sets `flag_wcol`, and the write has no effect on the frame being sent.
- R13: After reset `busy`, `flag_done`, `flag_wcol` and `miso_oe` are 0, `rd_data` is 0, and `sck_o` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = clock owner, 0 = follower |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0 = capture on leading edge, 1 = capture on trailing edge |
| cfg_sw_ss_en | input | 1 | 1 = internal select comes from `cfg_sw_ss_lvl` |
| cfg_sw_ss_lvl | input | 1 | Software select level (1 = not selected) |
| cfg_div | input | DIV_W | Half-period length minus one, in system clocks |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | DW | Byte to load into the shift register |
| stat_rd | input | 1 | Status read strobe (arms flag clearing) |
| dat_rd | input | 1 | Data register read strobe |
| rd_data | output | DW | Last received byte |
| flag_done | output | 1 | Sticky frame completion flag |
| flag_wcol | output | 1 | Sticky write collision flag |
| busy | output | 1 | Frame in progress |
| sck_i | input | 1 | Serial clock in (follower) |
| sck_o | output | 1 | Serial clock out (clock owner) |
| mosi_i | input | 1 | Serial data from clock owner (follower) |
| mosi_o | output | 1 | Serial data to follower (clock owner) |
| miso_i | input | 1 | Serial data from follower (clock owner) |
| miso_o | output | 1 | Serial data to clock owner (follower) |
| miso_oe | output | 1 | Output enable for `miso_o` |
| sel_n_i | input | 1 | Select pin, active low |

## Verification
The clock-owner role is run over a vector table that covers all four polarity/phase pairs, several divider values, and both select sources with the pin at both levels. A bit-order or edge-choice mistake therefore shows up as a wrong byte in one direction, and a divider mistake shows up as a wrong half-period count. The follower role is driven by a modelled clock owner through a phase-1 multi-byte burst, a phase-0 burst with an illegal reload, and a frame cut short by a select rise. These separate the two write-window rules from each other and from the abort path. Directed cases cover the software select override and the status-then-data clearing order, which an early or missing clear would get wrong.

// File: rtl/spi_ss_pkg.sv
// Shared definitions for the serial peripheral.
// Assumes nothing beyond the standard language.
package spi_ss_pkg;
    // Level driven on an unused serial data line.
    localparam logic IDLE_LINE = 1'b1;

    // Kind of SCK transition seen in the current system clock cycle.
    typedef enum logic [1:0] {
        EK_NONE  = 2'd0,
        EK_LEAD  = 2'd1,
        EK_TRAIL = 2'd2
    } edge_kind_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes STAGES >= 1; every bit gets the same latency.
module spi_pin_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the pin levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
// Serial clock generator for the clock-owner role.
// Produces one tick every div+1 system clocks while run is high; each tick
// toggles SCK. Assumes run falls no later than the cycle after the last tick.
module spi_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             tick,
    output logic             lead
);
    logic [DIV_W-1:0] cnt;
    logic             phase;

    assign tick = run && (cnt == div);
    assign lead = tick && !phase;
    assign sck  = cpol ^ phase;

    // Count system clocks within a half period and flip the phase on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R4: once stopped, the clock returns to its idle level.
    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !phase);

    // R4: with a divider above zero no two ticks are adjacent.
    a_r4_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/spi_shift_unit.sv
// MSB-first shift register with edge counter for one frame.
// Phase 0: capture on leading edges, shift on trailing edges.
// Phase 1: capture on trailing edges, shift on the following leading edge;
// the last bit is shifted in straight away on the final trailing edge.
// Assumes load never coincides with an edge (enforced by the write window).
module spi_shift_unit
    import spi_ss_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  edge_kind_e    ekind,
    input  logic          cpha,
    input  logic          din,
    input  logic          abort,
    output logic [DW-1:0] shreg,
    output logic          at_last,
    output logic          idle,
    output logic          frame_done
);
    localparam int               EDGES = 2 * DW;
    localparam int               CW    = $clog2(EDGES);
    localparam logic [CW-1:0]    LAST  = CW'(EDGES - 1);

    logic [CW-1:0] ecnt;
    logic          cap;

    assign at_last = (ecnt == LAST);
    assign idle    = (ecnt == '0);

    // Track edges, capture incoming bits and shift the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            ecnt  <= '0;
            cap   <= 1'b0;
        end else begin
            if (abort)
                ecnt <= '0;
            else if (ekind != EK_NONE)
                ecnt <= at_last ? '0 : ecnt + 1'b1;

            if (load) begin
                shreg <= load_data;
            end else if (!abort) begin
                case (ekind)
                    EK_LEAD: begin
                        if (!cpha)
                            cap <= din;
                        else if (!idle)
                            shreg <= {shreg[DW-2:0], cap};
                    end
                    EK_TRAIL: begin
                        if (!cpha)
                            shreg <= {shreg[DW-2:0], cap};
                        else if (at_last)
                            shreg <= {shreg[DW-2:0], din};
                        else
                            cap <= din;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Flag the cycle after the final trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_done <= 1'b0;
        else
            frame_done <= !abort && (ekind == EK_TRAIL) && at_last;
    end

    // R4: completion only follows the last edge of the frame.
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(at_last));

    // R10: an abort empties the edge count and yields no completion.
    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (idle && !frame_done));
endmodule

// File: rtl/spi_ss_core.sv
// Serial peripheral, clock owner or follower, with software-overridable
// select. Resolves the internal select, enforces the follower write window
// by phase, keeps sticky done/collision flags cleared by status-then-data.
// Assumes configuration inputs are held steady while a frame is in progress.
module spi_ss_core
    import spi_ss_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_sw_ss_en,
    input  logic             cfg_sw_ss_lvl,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             stat_rd,
    input  logic             dat_rd,
    output logic [DW-1:0]    rd_data,
    output logic             flag_done,
    output logic             flag_wcol,
    output logic             busy,
    input  logic             sck_i,
    output logic             sck_o,
    input  logic             mosi_i,
    output logic             mosi_o,
    input  logic             miso_i,
    output logic             miso_o,
    output logic             miso_oe,
    input  logic             sel_n_i
);
    localparam int           NPINS   = 3;
    localparam logic [NPINS-1:0] PIN_RST = {1'b1, 1'b0, 1'b0};

    logic       sel_s, sck_s, mosi_s;
    logic       sck_q;
    logic       sel_int;
    logic       slave_act;
    logic       m_busy;
    logic       tick, m_lead;
    logic       s_edge, s_lead;
    edge_kind_e ekind;
    logic       din;
    logic       abort;
    logic       load;
    logic       wr_ok;
    logic       wcol_set;
    logic       clr_arm, clr_now;
    logic [DW-1:0] shreg;
    logic       at_last, sh_idle, frame_done;

    spi_pin_sync #(
        .W       (NPINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n_i, sck_i, mosi_i}),
        .q     ({sel_s, sck_s, mosi_s})
    );

    // Internal select: software level overrides the synchronised pin.
    assign sel_int   = cfg_sw_ss_en ? cfg_sw_ss_lvl : sel_s;
    assign slave_act = !cfg_master && !sel_int;

    // Remember the previous synchronised SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign s_edge = sck_s ^ sck_q;
    assign s_lead = s_edge && (sck_q == cfg_cpol);

    spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_busy),
        .cpol  (cfg_cpol),
        .div   (cfg_div),
        .sck   (sck_o),
        .tick  (tick),
        .lead  (m_lead)
    );

    // Pick the edge source for the active role.
    always_comb begin
        ekind = EK_NONE;
        if (cfg_master) begin
            if (tick) ekind = m_lead ? EK_LEAD : EK_TRAIL;
        end else if (slave_act && s_edge) begin
            ekind = s_lead ? EK_LEAD : EK_TRAIL;
        end
    end

    assign din   = cfg_master ? miso_i : mosi_s;
    assign abort = !cfg_master && sel_int;

    // Write window: owner needs select high and no frame; follower by phase.
    always_comb begin
        if (cfg_master) begin
            wr_ok    = !m_busy && sel_int;
            wcol_set = wr_en && m_busy;
        end else begin
            wr_ok    = sel_int || (cfg_cpha && sh_idle);
            wcol_set = wr_en && !wr_ok;
        end
    end

    assign load = wr_en && wr_ok;

    spi_shift_unit #(.DW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_data  (wr_data),
        .ekind      (ekind),
        .cpha       (cfg_cpha),
        .din        (din),
        .abort      (abort),
        .shreg      (shreg),
        .at_last    (at_last),
        .idle       (sh_idle),
        .frame_done (frame_done)
    );

    // Owner frame state: start on an accepted write, stop on the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            m_busy <= 1'b0;
        else if (!cfg_master)
            m_busy <= 1'b0;
        else if (load)
            m_busy <= 1'b1;
        else if (tick && at_last)
            m_busy <= 1'b0;
    end

    // Hold the received byte once a frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_data <= '0;
        else if (frame_done) rd_data <= shreg;
    end

    // Arm clearing on a status read; a later data access consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)                clr_arm <= 1'b0;
        else if (stat_rd)          clr_arm <= 1'b1;
        else if (wr_en || dat_rd)  clr_arm <= 1'b0;
    end

    assign clr_now = clr_arm && (wr_en || dat_rd) && !stat_rd;

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_done <= 1'b0;
            flag_wcol <= 1'b0;
        end else begin
            flag_done <= frame_done || (flag_done && !clr_now);
            flag_wcol <= wcol_set   || (flag_wcol && !clr_now);
        end
    end

    assign busy    = m_busy || (!cfg_master && !sh_idle);
    assign mosi_o  = cfg_master ? shreg[DW-1] : IDLE_LINE;
    assign miso_oe = slave_act;
    assign miso_o  = slave_act ? shreg[DW-1] : IDLE_LINE;

    // R3: owner write with select low never starts a frame.
    a_r3_owner_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !m_busy && !sel_int && wr_en) |=> !m_busy);

    // R7: phase-0 follower write while selected raises a collision.
    a_r7_low_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && !cfg_cpha && !sel_int && wr_en) |=> flag_wcol);

    // R9: collision flag persists until a proper clear.
    a_r9_wcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wcol && !clr_now) |=> flag_wcol);

    // R11: an undriven data line rests high.
    a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> miso_o);

    // R12: owner write during a frame is reported as a collision.
    a_r12_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && m_busy && wr_en) |=> flag_wcol);
endmodule

// File: tb/sim_spi_ss_core.sv
module sim_spi_ss_core;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_master, cfg_cpol, cfg_cpha, cfg_sw_ss_en, cfg_sw_ss_lvl;
    logic [7:0] cfg_div;
    logic       wr_en, stat_rd, dat_rd;
    logic [7:0] wr_data, rd_data;
    logic       flag_done, flag_wcol, busy;
    logic       sck_i, sck_o, mosi_i, mosi_o, miso_i, miso_o, miso_oe, sel_n_i;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spi_ss_core u0 (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_sw_ss_en(cfg_sw_ss_en), .cfg_sw_ss_lvl(cfg_sw_ss_lvl),
        .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd),
        .dat_rd(dat_rd), .rd_data(rd_data), .flag_done(flag_done), .flag_wcol(flag_wcol),
        .busy(busy), .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .sel_n_i(sel_n_i)
    );

    // Vector fields: [27] cpol, [26] cpha, [25] sw select, [24] pin level,
    // [23:16] divider, [15:8] byte sent by the block, [7:0] byte sent back.
    localparam logic [27:0] MVEC [7] = '{
        28'h1_01_A5_3C,
        28'h5_00_C3_7E,
        28'h9_02_0F_F0,
        28'hD_01_81_18,
        28'h2_00_FF_00,
        28'hE_03_5A_A5,
        28'h1_00_96_69
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_flags();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Clock-owner frame against a modelled follower on miso_i/mosi_o.
    task automatic run_master(input logic [27:0] v, input bit poke, input string tag);
        logic       cp;
        logic       ph;
        logic [7:0] tx, stx, got;
        logic       psck, pmosi, cur;
        int         edges, since, dv, g;
        bit         perr, poked;
        cp = v[27]; ph = v[26]; dv = int'(v[23:16]); tx = v[15:8]; stx = v[7:0];
        cfg_master = 1'b1; cfg_cpol = cp; cfg_cpha = ph; cfg_sw_ss_en = v[25];
        cfg_sw_ss_lvl = 1'b1; sel_n_i = v[24]; cfg_div = v[23:16]; sck_i = cp;
        wait_n(4);
        clr_flags();
        miso_i = stx[7];
        @(negedge clk); wr_data = tx; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        psck = sck_o; pmosi = mosi_o; edges = 0; since = 0; perr = 0; poked = 0;
        got = '0; g = 0;
        while (edges < 16 && g < 4000) begin
            cur = sck_o;
            since++;
            if (cur != psck) begin
                if (edges > 0 && since != dv + 1) perr = 1;
                since = 0;
                if (psck == cp) begin
                    if (!ph) got = {got[6:0], pmosi};
                    else     miso_i = stx[7 - edges/2];
                end else begin
                    if (!ph) begin
                        if (edges/2 < 7) miso_i = stx[6 - edges/2];
                    end else begin
                        got = {got[6:0], pmosi};
                    end
                end
                edges++;
            end
            if (poke && edges == 4 && !poked) begin
                wr_data = ~tx; wr_en = 1'b1; poked = 1;
            end else begin
                wr_en = 1'b0;
            end
            psck = cur; pmosi = mosi_o;
            g++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        wait_n(3);
        check(got == tx,        {"R4 R5 mosi byte ", tag}, got, tx);
        check(rd_data == stx,   {"R4 R5 rd_data ", tag}, rd_data, stx);
        check(flag_done == 1'b1, {"R4 done ", tag}, flag_done, 1);
        check(!perr,            {"R4 half period ", tag}, perr, 0);
        check(!busy && sck_o == cp, {"R4 idle ", tag}, {busy, sck_o}, {1'b0, cp});
        if (poke) check(flag_wcol == 1'b1, {"R12 wcol ", tag}, flag_wcol, 1);
        else      check(flag_wcol == 1'b0, {"R1 R2 no wcol ", tag}, flag_wcol, 0);
    endtask

    // Follower frame: the bench owns SCK and MOSI and samples miso_o.
    task automatic s_xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        if (!cfg_cpha) begin
            mosi_i = tx[7];
            wait_n(2);
            for (int k = 0; k < nbits; k++) begin
                rx = {rx[6:0], miso_o};
                sck_i = ~cfg_cpol; wait_n(H);
                sck_i = cfg_cpol;
                if (k < 7) mosi_i = tx[6-k];
                wait_n(H);
            end
        end else begin
            for (int k = 0; k < nbits; k++) begin
                sck_i = ~cfg_cpol; mosi_i = tx[7-k]; wait_n(H);
                rx = {rx[6:0], miso_o};
                sck_i = cfg_cpol; wait_n(H);
            end
        end
        wait_n(4);
    endtask

    task automatic s_setup(input logic cp, input logic ph);
        cfg_master = 1'b0; cfg_cpol = cp; cfg_cpha = ph; cfg_sw_ss_en = 1'b0;
        cfg_sw_ss_lvl = 1'b1; sck_i = cp; sel_n_i = 1'b1;
        wait_n(5);
        clr_flags();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] rx;
        rst_n = 1'b0; cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
        cfg_sw_ss_en = 1'b0; cfg_sw_ss_lvl = 1'b0; cfg_div = 8'd1;
        wr_en = 1'b0; wr_data = '0; stat_rd = 1'b0; dat_rd = 1'b0;
        sck_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0; sel_n_i = 1'b1;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);

        // R13 reset state, R11 idle data line.
        check(!busy && !flag_done && !flag_wcol, "R13 flags after reset",
              {busy, flag_done, flag_wcol}, 0);
        check(rd_data == 8'h00 && sck_o == 1'b0, "R13 data and clock after reset",
              {rd_data, sck_o}, 0);
        check(!miso_oe && miso_o, "R11 line idle after reset", {miso_oe, miso_o}, 1);

        // Clock-owner vectors: R1 (software select with pin low), R2, R4, R5.
        for (int i = 0; i < 7; i++) run_master(MVEC[i], 1'b0, $sformatf("vec%0d", i));

        // R12: write during an owner frame.
        run_master(28'h1_02_3C_C3, 1'b1, "poke");

        // R3: software select low blocks an owner start.
        cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 8'd1;
        cfg_sw_ss_en = 1'b1; cfg_sw_ss_lvl = 1'b0; sel_n_i = 1'b1;
        wait_n(4); clr_flags();
        do_write(8'h11); wait_n(3);
        check(!busy && !flag_wcol && sck_o == 1'b0, "R3 blocked by software level",
              {busy, flag_wcol, sck_o}, 0);
        // R2 with R3: pin low blocks an owner start when software select is off.
        cfg_sw_ss_en = 1'b0; sel_n_i = 1'b0; wait_n(4);
        do_write(8'h22); wait_n(3);
        check(!busy && !flag_wcol, "R2 R3 blocked by pin", {busy, flag_wcol}, 0);
        sel_n_i = 1'b1;

        // R1/R2 follower select source.
        s_setup(1'b0, 1'b0);
        cfg_sw_ss_en = 1'b1; cfg_sw_ss_lvl = 1'b0; wait_n(4);
        check(miso_oe == 1'b1, "R1 software select, pin high", miso_oe, 1);
        cfg_sw_ss_lvl = 1'b1; wait_n(2);
        check(miso_oe == 1'b0, "R1 software deselect", miso_oe, 0);
        cfg_sw_ss_en = 1'b0; sel_n_i = 1'b0; wait_n(5);
        check(miso_oe == 1'b1, "R2 pin select", miso_oe, 1);
        sel_n_i = 1'b1; wait_n(5);

        // R6, R8: phase-1 follower, two bytes with select held low.
        s_setup(1'b1, 1'b1);
        do_write(8'hA5);
        sel_n_i = 1'b0; wait_n(H);
        s_xfer(8'h3C, 8, rx);
        check(rx == 8'hA5, "R6 R5 first byte out", rx, 8'hA5);
        check(rd_data == 8'h3C && flag_done, "R6 first byte in", {flag_done, rd_data}, 9'h13C);
        do_write(8'h96); wait_n(2);
        check(!flag_wcol, "R8 write between phase-1 bytes", flag_wcol, 0);
        s_xfer(8'hC3, 8, rx);
        check(rx == 8'h96, "R6 second byte out", rx, 8'h96);
        check(rd_data == 8'hC3, "R6 second byte in", rd_data, 8'hC3);
        sel_n_i = 1'b1; wait_n(H);

        // R7, R8, R9: phase-0 follower.
        s_setup(1'b0, 1'b0);
        do_write(8'h5A); wait_n(2);
        check(!flag_wcol, "R8 write with select high", flag_wcol, 0);
        sel_n_i = 1'b0; wait_n(H);
        s_xfer(8'h81, 8, rx);
        check(rx == 8'h5A && rd_data == 8'h81, "R5 phase-0 exchange", {rx, rd_data}, 16'h5A81);
        do_write(8'h77); wait_n(2);
        check(flag_wcol == 1'b1, "R7 write with select low", flag_wcol, 1);
        sel_n_i = 1'b1; wait_n(H);
        sel_n_i = 1'b0; wait_n(H);
        s_xfer(8'h24, 8, rx);
        check(rx == 8'h81, "R7 discarded byte not sent", rx, 8'h81);
        check(rd_data == 8'h24, "R7 next byte received", rd_data, 8'h24);
        sel_n_i = 1'b1; wait_n(H);
        check(flag_wcol && flag_done, "R9 flags stay set", {flag_wcol, flag_done}, 3);
        @(negedge clk); dat_rd = 1'b1; @(negedge clk); dat_rd = 1'b0; wait_n(1);
        check(flag_wcol && flag_done, "R9 data access alone keeps flags",
              {flag_wcol, flag_done}, 3);
        clr_flags(); wait_n(1);
        check(!flag_wcol && !flag_done, "R9 status then data clears",
              {flag_wcol, flag_done}, 0);

        // R10, R11: select rises mid-frame.
        do_write(8'hF0);
        sel_n_i = 1'b0; wait_n(H);
        s_xfer(8'h55, 3, rx);
        sel_n_i = 1'b1; wait_n(H);
        check(!flag_done && !busy, "R10 aborted frame not completed", {flag_done, busy}, 0);
        check(!miso_oe && miso_o, "R11 line idle when deselected", {miso_oe, miso_o}, 1);
        do_write(8'h0F);
        sel_n_i = 1'b0; wait_n(H);
        s_xfer(8'h69, 8, rx);
        check(rx == 8'h0F && rd_data == 8'h69 && flag_done, "R10 full frame after abort",
              {flag_done, rx, rd_data}, {1'b1, 16'h0F69});
        sel_n_i = 1'b1; wait_n(H);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule